// File: doc/BRIEF.md
# Early Victim Reservation Tracker

This block keeps track of outstanding cache misses for a cache that picks its victim way at the moment of the miss. Each accepted miss takes one entry that holds only the line address, the set, the way reserved for the refill and a few control bits. None of the entries holds line data. When the refill comes back, the data can go straight into the reserved way of the array. This removes the need for a data buffer per miss.

A later miss can land on a set and way that an earlier pending entry has already reserved. In that case the earlier entry is marked as displaced and is given one slot of a small spill buffer. Slots are handed out in strict circular order. When a fill response arrives it carries the entry index. In that same cycle the tracker raises exactly one write strobe: either to the array, at the reserved set and way, or to the spill buffer, at the entry's slot. The fill retires the entry. A spill slot stays busy until its contents are drained, which is signalled on a separate input.

Top module: `victim_reserve_tracker`

## Requirements
- R1: After reset, miss_ready is 1, and a fill response to any entry raises neither arr_we nor spill_we.
- R2: An accepted miss is placed in the lowest-numbered free entry, and that index appears on miss_id in the cycle of acceptance.
- R3: A fill to a pending entry that has not been displaced raises arr_we in the same cycle as fill_valid. arr_addr, arr_set and arr_way then carry the address, set and way recorded for that entry.
- R4: Misses to one set that reserve different ways do not displace each other, and each of their fills goes to the array.
- R5: A miss whose set and way equal those of a pending, non-displaced entry marks that entry as displaced. That entry's fill then raises spill_we, not arr_we.
- R6: Spill slots are granted in circular order 0, 1, 0, …. spill_slot on a displaced entry's fill shows the slot that was granted to it.
- R7: miss_ready is 0 while all entries are pending.
- R8: A miss that would displace an entry is stalled (miss_ready 0) while the slot at the circular pointer is still busy. Stalling that miss changes no state.
- R9: A fill retires its entry, and the entry becomes free for later misses. A fill to an entry that is not pending raises no write strobe.
- R10: drain_valid frees slot drain_slot, so that a displacing miss that was stalled on that slot is accepted.
- R11: In any cycle at most one of arr_we and spill_we is high.
- R12: A miss that displaced an earlier entry holds the reservation itself, so its own fill goes to the array.
- R13: An entry that receives its fill in the same cycle as a miss to its set and way is not displaced. The new miss takes the reservation, and no spill slot is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A new miss is offered |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_set | input | SET_W | Set index of the miss |
| miss_way | input | WAY_W | Victim way chosen at miss time |
| miss_ready | output | 1 | The miss is accepted this cycle |
| miss_id | output | log2(ENTRIES) | Entry index given to the accepted miss |
| fill_valid | input | 1 | A fill response is present |
| fill_id | input | log2(ENTRIES) | Entry the fill belongs to |
| arr_we | output | 1 | Write the fill into the cache array |
| arr_addr | output | ADDR_W | Line address of the array write |
| arr_set | output | SET_W | Set of the array write |
| arr_way | output | WAY_W | Way of the array write |
| spill_we | output | 1 | Write the fill into the spill buffer |
| spill_slot | output | log2(SLOTS) | Spill slot of the write |
| drain_valid | input | 1 | A spill slot has been drained |
| drain_slot | input | log2(SLOTS) | Slot that is being freed |

## Verification
The bench drives the main function with five kinds of input pattern. A sweep of four distinct sets fills the table, which exposes the lowest-free allocation and the stall when the table is full. A sweep of four ways within one set separates a match on set alone from a match on set and way. A chain of repeated misses to one set and way displaces entry after entry. This shows which entry the data is steered to, the order in which slots are granted, and the stall when the slot at the pointer is busy. A fill that coincides with a conflicting miss tells apart a retiring entry from one that is still pending. A later conflict then confirms that the slot pointer did not move in that case.

// File: rtl/victim_reserve_tracker.sv
module victim_reserve_tracker #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 2,
  parameter int ADDR_W  = 16,
  parameter int SET_W   = 4,
  parameter int WAY_W   = 2,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [SET_W-1:0]  miss_set,
  input  logic [WAY_W-1:0]  miss_way,
  output logic              miss_ready,
  output logic [IW-1:0]     miss_id,
  input  logic              fill_valid,
  input  logic [IW-1:0]     fill_id,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [SET_W-1:0]  arr_set,
  output logic [WAY_W-1:0]  arr_way,
  output logic              spill_we,
  output logic [SW-1:0]     spill_slot,
  input  logic              drain_valid,
  input  logic [SW-1:0]     drain_slot
);

  logic [ENTRIES-1:0] ent_v, ent_thr, hit;
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [SET_W-1:0]   ent_set  [ENTRIES];
  logic [WAY_W-1:0]   ent_way  [ENTRIES];
  logic [SW-1:0]      ent_slot [ENTRIES];
  logic [SLOTS-1:0]   slot_busy;
  logic [SW-1:0]      spill_ptr, ptr_next;

  logic          have_free, thr_hit, accept, fill_live;
  logic [IW-1:0] free_idx, vic_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_v[i]) begin
        have_free = 1'b1;
        free_idx  = IW'(i);
      end
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i] = ent_v[i] && !ent_thr[i] && ent_set[i] == miss_set &&
               ent_way[i] == miss_way && !(fill_valid && fill_id == IW'(i));
      if (hit[i]) vic_idx = IW'(i);
    end
  end

  assign thr_hit    = |hit;
  assign ptr_next   = (spill_ptr == SW'(SLOTS - 1)) ? '0 : spill_ptr + 1'b1;
  assign miss_ready = have_free && (!thr_hit || !slot_busy[spill_ptr]);
  assign miss_id    = free_idx;
  assign accept     = miss_valid && miss_ready;

  assign fill_live  = fill_valid && ent_v[fill_id];
  assign arr_we     = fill_live && !ent_thr[fill_id];
  assign spill_we   = fill_live && ent_thr[fill_id];
  assign arr_addr   = ent_addr[fill_id];
  assign arr_set    = ent_set[fill_id];
  assign arr_way    = ent_way[fill_id];
  assign spill_slot = ent_slot[fill_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v     <= '0;
      ent_thr   <= '0;
      slot_busy <= '0;
      spill_ptr <= '0;
    end else begin
      if (fill_live) begin
        ent_v[fill_id]   <= 1'b0;
        ent_thr[fill_id] <= 1'b0;
      end
      if (drain_valid) slot_busy[drain_slot] <= 1'b0;
      if (accept) begin
        ent_v[free_idx]   <= 1'b1;
        ent_thr[free_idx] <= 1'b0;
        if (thr_hit) begin
          ent_thr[vic_idx]     <= 1'b1;
          slot_busy[spill_ptr] <= 1'b1;
          spill_ptr            <= ptr_next;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ent_addr[free_idx] <= miss_addr;
      ent_set[free_idx]  <= miss_set;
      ent_way[free_idx]  <= miss_way;
      if (thr_hit) ent_slot[vic_idx] <= spill_ptr;
    end
  end

endmodule

module victim_reserve_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 2,
  parameter int SET_W   = 4,
  parameter int WAY_W   = 2,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic               fill_valid,
  input logic               arr_we,
  input logic               spill_we,
  input logic               thr_hit,
  input logic [ENTRIES-1:0] ent_v,
  input logic [ENTRIES-1:0] ent_thr,
  input logic [SET_W-1:0]   ent_set [ENTRIES],
  input logic [WAY_W-1:0]   ent_way [ENTRIES],
  input logic [SLOTS-1:0]   slot_busy,
  input logic [SW-1:0]      spill_ptr
);

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (ent_v[i] && ent_v[j] && !ent_thr[i] && !ent_thr[j] &&
            ent_set[i] == ent_set[j] && ent_way[i] == ent_way[j])
          dup = 1'b1;
  end

  a_r11_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && spill_we));
  a_r3_write_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || spill_we) |-> fill_valid);
  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_v) |-> !miss_ready);
  a_r8_slot_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && slot_busy[spill_ptr]) |-> !miss_ready);
  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && thr_hit) |=>
      (spill_ptr == (($past(spill_ptr) == SW'(SLOTS - 1)) ? SW'(0) : SW'($past(spill_ptr) + 1'b1))));
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_valid && miss_ready && thr_hit) |=> $stable(spill_ptr));

endmodule

bind victim_reserve_tracker victim_reserve_tracker_chk #(
  .ENTRIES(ENTRIES), .SLOTS(SLOTS), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .fill_valid(fill_valid), .arr_we(arr_we), .spill_we(spill_we),
  .thr_hit(thr_hit), .ent_v(ent_v), .ent_thr(ent_thr), .ent_set(ent_set),
  .ent_way(ent_way), .slot_busy(slot_busy), .spill_ptr(spill_ptr)
);

// File: tb/victim_reserve_tracker_test.sv
module victim_reserve_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        miss_valid = 1'b0, fill_valid = 1'b0, drain_valid = 1'b0;
  logic [15:0] miss_addr = '0;
  logic [3:0]  miss_set = '0;
  logic [1:0]  miss_way = '0, fill_id = '0;
  logic        drain_slot = 1'b0;
  logic        miss_ready, arr_we, spill_we, spill_slot;
  logic [1:0]  miss_id, arr_way;
  logic [15:0] arr_addr;
  logic [3:0]  arr_set;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victim_reserve_tracker uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_set(miss_set), .miss_way(miss_way), .miss_ready(miss_ready),
    .miss_id(miss_id), .fill_valid(fill_valid), .fill_id(fill_id),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_set(arr_set), .arr_way(arr_way),
    .spill_we(spill_we), .spill_slot(spill_slot), .drain_valid(drain_valid),
    .drain_slot(drain_slot)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic miss(int s, int w, int a, int exp_rdy, int exp_id, string req);
    miss_valid = 1'b1; miss_set = 4'(s); miss_way = 2'(w); miss_addr = 16'(a);
    #1;
    chk({req, " ready"}, int'(miss_ready), exp_rdy);
    if (exp_rdy == 1) chk({req, " id"}, int'(miss_id), exp_id);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic fill(int id, int exp_arr, int exp_spill, int exp_set, int exp_way,
                      int exp_addr, int exp_slot, string req);
    fill_valid = 1'b1; fill_id = 2'(id);
    #1;
    chk({req, " arr_we"}, int'(arr_we), exp_arr);
    chk({req, " spill_we"}, int'(spill_we), exp_spill);
    if (exp_arr == 1) begin
      chk({req, " set"}, int'(arr_set), exp_set);
      chk({req, " way"}, int'(arr_way), exp_way);
      chk({req, " addr"}, int'(arr_addr), exp_addr);
    end
    if (exp_spill == 1) chk({req, " slot"}, int'(spill_slot), exp_slot);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic drain(int slot);
    drain_valid = 1'b1; drain_slot = 1'(slot);
    @(negedge clk);
    drain_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1 chk("R1 ready", int'(miss_ready), 1);
    for (int e = 0; e < 4; e++) fill(e, 0, 0, 0, 0, 0, 0, "R1 idle fill");

    // R2, R7: sweep distinct sets fills the table
    for (int s = 0; s < 4; s++) miss(s, s, 16'h100 + s, 1, s, "R2 alloc");
    miss(8, 0, 16'h200, 0, 0, "R7 full");
    for (int e = 3; e >= 0; e--) fill(e, 1, 0, e, e, 16'h100 + e, 0, "R3 direct");
    fill(3, 0, 0, 0, 0, 0, 0, "R9 retired");
    miss(8, 3, 16'h300, 1, 0, "R9 reuse");
    fill(0, 1, 0, 8, 3, 16'h300, 0, "R9 reuse fill");

    // R4: same set, different ways
    for (int w = 0; w < 4; w++) miss(5, w, 16'h500 + w, 1, w, "R4 alloc");
    for (int w = 0; w < 4; w++) fill(w, 1, 0, 5, w, 16'h500 + w, 0, "R4 direct");

    // R5, R6, R8, R12: displacement chain on one set and way
    miss(7, 1, 16'h700, 1, 0, "R5 first");
    miss(7, 1, 16'h701, 1, 1, "R5 second");
    miss(7, 1, 16'h702, 1, 2, "R6 third");
    miss(7, 1, 16'h703, 0, 0, "R8 slot busy");
    fill(0, 0, 1, 0, 0, 0, 0, "R5 spill");
    fill(1, 0, 1, 0, 0, 0, 1, "R6 second slot");
    fill(2, 1, 0, 7, 1, 16'h702, 0, "R12 owner");
    fill(3, 0, 0, 0, 0, 0, 0, "R8 stalled no entry");

    // R10: drain unblocks a stalled displacing miss; R6 wrap
    miss(9, 0, 16'h900, 1, 0, "R10 first");
    miss(9, 0, 16'h901, 0, 0, "R8 stall");
    drain(0);
    miss(9, 0, 16'h902, 1, 1, "R10 after drain");
    fill(0, 0, 1, 0, 0, 0, 0, "R6 wrap");
    fill(1, 1, 0, 9, 0, 16'h902, 0, "R12 owner2");
    drain(0);
    drain(1);

    // R13: fill and conflicting miss together
    miss(3, 2, 16'h330, 1, 0, "R13 first");
    fill_valid = 1'b1; fill_id = 2'd0;
    miss_valid = 1'b1; miss_set = 4'd3; miss_way = 2'd2; miss_addr = 16'h331;
    #1;
    chk("R13 ready", int'(miss_ready), 1);
    chk("R13 id", int'(miss_id), 1);
    chk("R13 arr_we", int'(arr_we), 1);
    chk("R11 spill_we", int'(spill_we), 0);
    @(negedge clk);
    fill_valid = 1'b0; miss_valid = 1'b0;
    fill(1, 1, 0, 3, 2, 16'h331, 0, "R13 new owner");
    miss(4, 0, 16'h440, 1, 0, "R13 ptr a");
    miss(4, 0, 16'h441, 1, 1, "R13 ptr b");
    fill(0, 0, 1, 0, 0, 0, 1, "R13 ptr unchanged");
    fill(1, 1, 0, 4, 0, 16'h441, 0, "R12 owner3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule